// File: doc/BRIEF.md
# Interrupt Router with Encoding Modes

This block takes a parameterised set of external interrupt sources and steers each of them to one interrupt pin of one processor. Every source owns a route word, written over a simple word-addressed register bus. Each route word holds an 8-bit processor field and a 4-bit pin field. By default both fields use a one-hot compatible form. In that form the upper nibble of the processor field names a group of four processors, and the lower nibble and the pin field are bitmaps. This reaches four processors per group and pins 0 to 3.

A configuration register can switch either field to a plain binary index. Binary indices reach processors 0 to 255 and pins 0 to 15. A switch only takes effect when the matching capability bit in a read-only feature register is set. Each source also has an enable bit and a capture mode, which is either level or rising edge. A captured edge is cleared by writing ones to the pending register. The outputs form a flat vector of pending levels, one bit for each (processor, pin) pair.

Top module: `irq_enc_router`

## Requirements
- R1: After synchronous reset, every pending output is 0, and the route words, enable register, edge-select register and configuration register all read 0.
- R2: In bitmap decoding, route bits [3:0] are a processor bitmap and bits [7:4] are a group number. The target processor is group*4 + index of the set bit. Route bits [11:8] are a pin bitmap. The output bit for processor c and pin p is bit c*NUM_PIN + p.
- R3: In bitmap decoding, a field with several bits set selects its lowest set bit. A processor bitmap or pin bitmap of zero routes the source nowhere. A target processor at or above NUM_CPU is not driven.
- R4: With configuration bit 0 set, route bits [11:8] are a binary pin index 0 to 15.
- R5: With configuration bit 1 set, route bits [7:0] are a binary processor index. An index at or above NUM_CPU drives no output.
- R6: A configuration bit whose capability bit is 0 cannot be set: it reads back 0, and decoding stays bitmap.
- R7: The feature register at word 0x13 reads {cpu_capability, pin_capability} in bits [1:0]. Writes to it are ignored.
- R8: A source whose enable bit (word 0x10) is 0 drives no output, whatever its input.
- R9: A level source (edge-select bit at word 0x11 equal to 0) is pending exactly while its input is high.
- R10: An edge source stays pending after its input falls, until a 1 is written to its bit of the pending register (word 0x12). The pending register reads back the per-source pending state.
- R11: When several enabled, pending sources route to the same target, that output is their OR.
- R12: A source input change appears at the outputs after two rising clock edges. A route or configuration write appears one edge after the edge that stores it.
- R13: The route word of source i is readable and writable at word i. The configuration register is at word 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | External interrupt source lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i (combinational) |
| irq_pend_o | output | NUM_CPU*NUM_PIN | Pending level per processor and pin, bit c*NUM_PIN+p |

## Verification
The capability fallback is the hardest case to reach from the ports. With a full-featured instance, the encoded path always hides the bitmap path. The bench therefore runs a second instance with both capabilities removed, on the same bus and sources. When the bench writes an encoded configuration, this second instance must read back 0 and decode the same route word as a bitmap, to a different target than the first instance. The edge hold is reached by raising and dropping the input before any clear is written. Multi-bit bitmaps and out-of-range processor numbers each have their own vectors.

// File: rtl/irq_enc_router_pkg.sv
package irq_enc_router_pkg;

    localparam int ROUTE_W = 12;
    localparam int CPU_W   = 8;
    localparam int PIN_W   = 4;
    localparam int ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] ADR_ENABLE = 5'h10;
    localparam logic [ADDR_W-1:0] ADR_EDGE   = 5'h11;
    localparam logic [ADDR_W-1:0] ADR_PEND   = 5'h12;
    localparam logic [ADDR_W-1:0] ADR_FEAT   = 5'h13;
    localparam logic [ADDR_W-1:0] ADR_CFG    = 5'h14;

    typedef logic [ROUTE_W-1:0] route_t;

    typedef struct packed {
        logic             ok;
        logic [CPU_W-1:0] cpu;
        logic [PIN_W-1:0] pin;
    } target_t;

    // Index of the lowest set bit of a 4-bit map (3 when only bit 3 or none).
    function automatic logic [1:0] low_idx(input logic [3:0] m);
        if (m[0])      return 2'd0;
        else if (m[1]) return 2'd1;
        else if (m[2]) return 2'd2;
        else           return 2'd3;
    endfunction

    function automatic target_t decode_route(input route_t r,
                                             input logic cpu_enc,
                                             input logic pin_enc);
        target_t t;
        logic    cpu_ok;
        logic    pin_ok;
        if (cpu_enc) begin
            t.cpu  = r[7:0];
            cpu_ok = 1'b1;
        end else begin
            t.cpu  = {2'b00, r[7:4], low_idx(r[3:0])};
            cpu_ok = |r[3:0];
        end
        if (pin_enc) begin
            t.pin  = r[11:8];
            pin_ok = 1'b1;
        end else begin
            t.pin  = {2'b00, low_idx(r[11:8])};
            pin_ok = |r[11:8];
        end
        t.ok = cpu_ok & pin_ok;
        return t;
    endfunction

endpackage

// File: rtl/irq_enc_regs.sv
module irq_enc_regs
    import irq_enc_router_pkg::*;
#(
    parameter int N_SRC       = 8,
    parameter bit HAS_PIN_ENC = 1'b1,
    parameter bit HAS_CPU_ENC = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic [N_SRC-1:0]  pend_i,
    output route_t            route_o [N_SRC],
    output logic [N_SRC-1:0]  en_o,
    output logic [N_SRC-1:0]  edge_o,
    output logic [1:0]        cfg_o,
    output logic [N_SRC-1:0]  clr_o
);
    localparam logic [1:0] FEAT = {HAS_CPU_ENC, HAS_PIN_ENC};

    route_t             route_q [N_SRC];
    logic [N_SRC-1:0]   en_q;
    logic [N_SRC-1:0]   edge_q;
    logic [1:0]         cfg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < N_SRC; i++) route_q[i] <= '0;
            en_q   <= '0;
            edge_q <= '0;
            cfg_q  <= '0;
        end else if (wr_i) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (addr_i == ADDR_W'(i)) route_q[i] <= wdata_i[ROUTE_W-1:0];
            end
            case (addr_i)
                ADR_ENABLE: en_q   <= wdata_i[N_SRC-1:0];
                ADR_EDGE:   edge_q <= wdata_i[N_SRC-1:0];
                ADR_CFG:    cfg_q  <= wdata_i[1:0] & FEAT;
                default: ;
            endcase
        end
    end

    assign clr_o = (wr_i && addr_i == ADR_PEND) ? wdata_i[N_SRC-1:0] : '0;

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (addr_i == ADDR_W'(i)) rdata_o = 32'(route_q[i]);
        end
        case (addr_i)
            ADR_ENABLE: rdata_o = 32'(en_q);
            ADR_EDGE:   rdata_o = 32'(edge_q);
            ADR_PEND:   rdata_o = 32'(pend_i);
            ADR_FEAT:   rdata_o = 32'(FEAT);
            ADR_CFG:    rdata_o = 32'(cfg_q);
            default: ;
        endcase
    end

    assign route_o = route_q;
    assign en_o    = en_q;
    assign edge_o  = edge_q;
    assign cfg_o   = cfg_q;

endmodule

// File: rtl/irq_src_cap.sv
module irq_src_cap (
    input  logic clk_i,
    input  logic rst_i,
    input  logic in_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= in_i;
            if (edge_mode_i)
                pend_q <= (pend_q & ~clr_i) | (in_i & ~prev_q);
            else
                pend_q <= in_i;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_target_map.sv
module irq_target_map
    import irq_enc_router_pkg::*;
#(
    parameter int N_SRC   = 8,
    parameter int NUM_CPU = 8,
    parameter int NUM_PIN = 16
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  route_t                     route_i [N_SRC],
    input  logic [N_SRC-1:0]           active_i,
    input  logic                       cpu_enc_i,
    input  logic                       pin_enc_i,
    output logic [NUM_CPU*NUM_PIN-1:0] irq_o
);
    localparam int OUT_W = NUM_CPU * NUM_PIN;

    target_t          tgt [N_SRC];
    logic [OUT_W-1:0] irq_d;
    logic [OUT_W-1:0] irq_q;

    for (genvar s = 0; s < N_SRC; s++) begin : g_dec
        assign tgt[s] = decode_route(route_i[s], cpu_enc_i, pin_enc_i);
    end

    always_comb begin
        irq_d = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int p = 0; p < NUM_PIN; p++) begin
                for (int s = 0; s < N_SRC; s++) begin
                    if (active_i[s] && tgt[s].ok &&
                        tgt[s].cpu == CPU_W'(c) && tgt[s].pin == PIN_W'(p))
                        irq_d[c*NUM_PIN+p] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) irq_q <= '0;
        else       irq_q <= irq_d;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_enc_router.sv
module irq_enc_router
    import irq_enc_router_pkg::*;
#(
    parameter int N_SRC       = 8,
    parameter int NUM_CPU     = 8,
    parameter int NUM_PIN     = 16,
    parameter bit HAS_PIN_ENC = 1'b1,
    parameter bit HAS_CPU_ENC = 1'b1
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [N_SRC-1:0]           src_i,
    input  logic                       bus_wr_i,
    input  logic [4:0]                 bus_addr_i,
    input  logic [31:0]                bus_wdata_i,
    output logic [31:0]                bus_rdata_o,
    output logic [NUM_CPU*NUM_PIN-1:0] irq_pend_o
);
    route_t           route_q [N_SRC];
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] edge_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] clr_w;
    logic [1:0]       cfg_q;

    irq_enc_regs #(
        .N_SRC      (N_SRC),
        .HAS_PIN_ENC(HAS_PIN_ENC),
        .HAS_CPU_ENC(HAS_CPU_ENC)
    ) regs_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .wr_i   (bus_wr_i),
        .addr_i (bus_addr_i),
        .wdata_i(bus_wdata_i),
        .rdata_o(bus_rdata_o),
        .pend_i (pend_q),
        .route_o(route_q),
        .en_o   (en_q),
        .edge_o (edge_q),
        .cfg_o  (cfg_q),
        .clr_o  (clr_w)
    );

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        irq_src_cap cap_i (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .in_i       (src_i[s]),
            .edge_mode_i(edge_q[s]),
            .clr_i      (clr_w[s]),
            .pend_o     (pend_q[s])
        );
    end

    irq_target_map #(
        .N_SRC  (N_SRC),
        .NUM_CPU(NUM_CPU),
        .NUM_PIN(NUM_PIN)
    ) map_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .route_i  (route_q),
        .active_i (en_q & pend_q),
        .cpu_enc_i(cfg_q[1]),
        .pin_enc_i(cfg_q[0]),
        .irq_o    (irq_pend_o)
    );

endmodule

// File: rtl/irq_enc_router_chk.sv
module irq_enc_router_chk
    import irq_enc_router_pkg::*;
#(
    parameter int N_SRC       = 8,
    parameter int OUT_W       = 128,
    parameter bit HAS_PIN_ENC = 1'b1,
    parameter bit HAS_CPU_ENC = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             wr,
    input logic [4:0]       addr,
    input logic [31:0]      rdata,
    input logic [OUT_W-1:0] irq,
    input logic [N_SRC-1:0] en,
    input logic [N_SRC-1:0] edge_m,
    input logic [N_SRC-1:0] pend
);
    localparam logic [31:0] FEAT_W = 32'({HAS_CPU_ENC, HAS_PIN_ENC});

    logic [N_SRC-1:0] held;
    assign held = pend & edge_m;

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (irq == '0));

    p_cfg_capped_r6: assert property (@(posedge clk) disable iff (rst)
        (addr == ADR_CFG) |-> ((rdata & ~FEAT_W) == '0));

    p_feat_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        (addr == ADR_FEAT) |-> (rdata == FEAT_W));

    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |=> (irq == '0));

    p_edge_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr) |=> ((pend & $past(held)) == $past(held)));

endmodule

bind irq_enc_router irq_enc_router_chk #(
    .N_SRC      (N_SRC),
    .OUT_W      (NUM_CPU*NUM_PIN),
    .HAS_PIN_ENC(HAS_PIN_ENC),
    .HAS_CPU_ENC(HAS_CPU_ENC)
) chk_i (
    .clk   (clk_i),
    .rst   (rst_i),
    .wr    (bus_wr_i),
    .addr  (bus_addr_i),
    .rdata (bus_rdata_o),
    .irq   (irq_pend_o),
    .en    (en_q),
    .edge_m(edge_q),
    .pend  (pend_q)
);

// File: tb/irq_enc_router_tb_top.sv
module irq_enc_router_tb_top;
    import irq_enc_router_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_SRC      = 8;
    localparam int NUM_CPU    = 8;
    localparam int NUM_PIN    = 16;
    localparam int OUT_W      = NUM_CPU * NUM_PIN;

    typedef struct packed {
        logic [1:0]  cfg;
        logic [11:0] route;
        logic        hit;
        logic [7:0]  idx;
    } vec_t;

    // idx = cpu*16 + pin
    localparam vec_t VEC [11] = '{
        '{2'd0, 12'h101, 1'b1, 8'd0},    // R2 group0 cpu0 pin0
        '{2'd0, 12'h214, 1'b1, 8'd97},   // R2 group1 bit2 -> cpu6, pin1
        '{2'd0, 12'hA0C, 1'b1, 8'd33},   // R3 multi-bit -> cpu2 pin1
        '{2'd0, 12'h300, 1'b0, 8'd0},    // R3 empty cpu bitmap
        '{2'd0, 12'h001, 1'b0, 8'd0},    // R3 empty pin bitmap
        '{2'd0, 12'h121, 1'b0, 8'd0},    // R3 group2 -> cpu8 out of range
        '{2'd1, 12'hF01, 1'b1, 8'd15},   // R4 encoded pin 15
        '{2'd2, 12'h105, 1'b1, 8'd80},   // R5 encoded cpu5, bitmap pin0
        '{2'd3, 12'h907, 1'b1, 8'd121},  // R4 R5 cpu7 pin9
        '{2'd2, 12'h120, 1'b0, 8'd0},    // R5 cpu32 out of range
        '{2'd3, 12'h003, 1'b1, 8'd48}    // R4 encoded pin0, cpu3
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N_SRC-1:0] src = '0;
    logic             wr = 1'b0;
    logic [4:0]       addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata, rdata_nf;
    logic [OUT_W-1:0] irq, irq_nf;
    int               n_tests = 0;
    int               n_fail = 0;
    logic [31:0]      rd, rd_nf;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_enc_router #(.N_SRC(N_SRC), .NUM_CPU(NUM_CPU), .NUM_PIN(NUM_PIN),
                     .HAS_PIN_ENC(1'b1), .HAS_CPU_ENC(1'b1)) dut_i (
        .clk_i(clk), .rst_i(rst), .src_i(src), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_pend_o(irq));

    irq_enc_router #(.N_SRC(N_SRC), .NUM_CPU(NUM_CPU), .NUM_PIN(NUM_PIN),
                     .HAS_PIN_ENC(1'b0), .HAS_CPU_ENC(1'b0)) dut_nf_i (
        .clk_i(clk), .rst_i(rst), .src_i(src), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata_nf), .irq_pend_o(irq_nf));

    function automatic logic [OUT_W-1:0] bit_at(input int idx);
        return OUT_W'(1) << idx;
    endfunction

    task automatic check(input string req, input logic [OUT_W-1:0] act,
                         input logic [OUT_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a);
        @(negedge clk);
        addr = a;
        #1;
        rd = rdata;
        rd_nf = rdata_nf;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        settle(3);
        rst = 1'b0;
        settle(1);
        // R1 reset state
        check("R1 outputs", irq, '0);
        bus_read(ADR_CFG);    check("R1 cfg", OUT_W'(rd), '0);
        bus_read(5'd0);       check("R1 route0", OUT_W'(rd), '0);
        bus_read(ADR_ENABLE); check("R1 enable", OUT_W'(rd), '0);
        bus_read(ADR_EDGE);   check("R1 edge", OUT_W'(rd), '0);

        // R7 feature register
        bus_read(ADR_FEAT);   check("R7 feat full", OUT_W'(rd), OUT_W'(3));
        check("R7 feat none", OUT_W'(rd_nf), '0);
        bus_write(ADR_FEAT, 32'h0);
        bus_read(ADR_FEAT);   check("R7 feat after write", OUT_W'(rd), OUT_W'(3));

        // Vector walk on source 0 (level, enabled, input high)
        bus_write(ADR_ENABLE, 32'h1);
        src[0] = 1'b1;
        foreach (VEC[i]) begin
            bus_write(ADR_CFG, 32'(VEC[i].cfg));
            bus_write(5'd0, 32'(VEC[i].route));
            settle(1);
            check($sformatf("R2-5 vector %0d", i), irq,
                  VEC[i].hit ? bit_at(int'(VEC[i].idx)) : '0);
            if (VEC[i].route == 12'h907) begin
                // R6 fallback: no capability -> bitmap, cpu0 pin0
                check("R6 fallback decode", irq_nf, bit_at(0));
            end
        end
        bus_read(ADR_CFG);
        check("R6 cfg capped", OUT_W'(rd_nf), '0);
        check("R13 cfg readback", OUT_W'(rd), OUT_W'(3));
        bus_read(5'd0);
        check("R13 route readback", OUT_W'(rd), OUT_W'(12'h003));

        // R12 latency, level source 0 routed to cpu0 pin0
        bus_write(ADR_CFG, 32'h0);
        bus_write(5'd0, 32'h101);
        src[0] = 1'b0;
        settle(2);
        check("R9 level low", irq, '0);
        src[0] = 1'b1;
        settle(1);
        check("R12 one edge", irq, '0);
        settle(1);
        check("R12 two edges", irq, bit_at(0));
        src[0] = 1'b0;
        settle(2);
        check("R9 level follows", irq, '0);

        // R8 disabled source
        bus_write(ADR_ENABLE, 32'h0);
        src[0] = 1'b1;
        settle(2);
        check("R8 disabled", irq, '0);
        src[0] = 1'b0;

        // R11 OR of two level sources on cpu0 pin0
        bus_write(5'd1, 32'h101);
        bus_write(ADR_ENABLE, 32'h3);
        src[1] = 1'b1;
        settle(2);
        check("R11 src1 only", irq, bit_at(0));
        src[0] = 1'b1;
        settle(2);
        check("R11 both", irq, bit_at(0));
        src[1] = 1'b0;
        settle(2);
        check("R11 src0 only", irq, bit_at(0));
        src[0] = 1'b0;
        settle(2);
        check("R11 none", irq, '0);

        // R10 edge capture on source 1, routed to cpu1 pin2
        bus_write(5'd1, 32'h402);
        bus_write(ADR_ENABLE, 32'h2);
        bus_write(ADR_EDGE, 32'h2);
        src[1] = 1'b1;
        settle(2);
        check("R10 edge set", irq, bit_at(1*16+2));
        src[1] = 1'b0;
        settle(2);
        check("R10 edge held", irq, bit_at(1*16+2));
        bus_read(ADR_PEND);
        check("R10 pend readback", OUT_W'(rd), OUT_W'(2));
        bus_write(ADR_PEND, 32'h2);
        settle(1);
        check("R10 cleared", irq, '0);
        bus_read(ADR_PEND);
        check("R10 pend cleared", OUT_W'(rd), '0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule